// File: doc/BRIEF.md
# Timer Compare Output Channel with Edge-Aligned PWM

This block drives one output pin from comparisons between an external free-running timer count and two values held in the channel. A 3-bit mode input selects what a match does: force the pin high once, force it low once, toggle it on every match, or run an edge-aligned pulse-width modulator. In PWM mode the duty value is double-buffered. Software writes a secondary duty register at any time, and that value moves into the active compare only at the period boundary, which the timer announces with a one-cycle period-match pulse.

The channel is written so that a pin never changes unless a real event asks for it. Entering any mode leaves the present level alone until the first match or boundary. A zero duty is a true 0% with no stray one-cycle high. The first nonzero duty written after a run of zero periods takes effect at the next boundary, like any other value. Each match that acts on the pin, and each PWM boundary, raises a one-cycle event pulse.

Top module: `oc_pwm_chan`

## Requirements
- R1: While rst_ni is low, pin_o and irq_o are 0, and the stored compare and duty values are cleared to 0.
- R2: With mode code 1, the pin goes to 1 after the first clock edge where tmr_i equals the compare value since the mode was entered. Later matches in the same mode leave the pin alone and raise no event.
- R3: With mode code 2, the pin goes to 0 after the first clock edge where tmr_i equals the compare value since the mode was entered. Later matches in the same mode leave the pin alone and raise no event.
- R4: With mode code 3, the pin inverts after every clock edge where tmr_i equals the compare value.
- R5: The edge at which mode_i takes a new value does not change the pin unless that same edge carries a match, or a boundary in PWM mode.
- R6: Mode code 0 and the unused codes 4, 5 and 7 hold the pin at its last level and raise no event.
- R7: With mode code 6 and an active duty D, 0 < D < period, the pin is 1 after the edges where tmr_i is 0 to D-1, and it falls after the edge where tmr_i equals D.
- R8: A duty write has no effect on the pin until the next edge where prd_match_i is 1. At that edge the last written value becomes active, and the pin goes to 1 if that value is nonzero and to 0 if it is zero. Entering mode 6 also copies the written value into the active duty.
- R9: A duty of 0 holds the pin at 0 for the whole period with no high cycle. A nonzero duty written during such a period takes full effect in the period that follows.
- R10: A duty greater than or equal to the period (the tmr_i value at prd_match_i) holds the pin at 1 for the whole period.
- R11: irq_o is a one-cycle pulse after each edge at which a match acts on the pin (modes 1 to 3), and after each edge where prd_match_i is 1 in mode 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_i | input | CNT_W | Free-running timer count |
| prd_match_i | input | 1 | One-cycle pulse in the last count of a timer period |
| mode_i | input | 3 | Mode code: 0 off, 1 set, 2 clear, 3 toggle, 6 PWM, others off |
| cmp_wr_i | input | 1 | Write strobe for the compare value |
| cmp_wdata_i | input | CNT_W | Compare value to store |
| dty_wr_i | input | 1 | Write strobe for the secondary duty value |
| dty_wdata_i | input | CNT_W | Duty value to store |
| pin_o | output | 1 | Compare output level |
| irq_o | output | 1 | One-cycle event pulse |

## Verification
Each fault in the stored state shows on pin_o one clock after the edge that uses it. A stale single-shot arm gives a second transition, or no transition, in the period after the match. A duty loaded early or late moves a falling edge inside the current period. A wrong decision at the boundary shows as a one-cycle high at 0% duty, or as a missing rising edge in the period after a zero duty. Sweeping every compare and duty value of a 4-bit timer with a period of 9 puts each of these faults on the pin within one or two periods.

// File: rtl/oc_pwm_pkg.sv
package oc_pwm_pkg;
  localparam logic [2:0] MODE_OFF = 3'd0;
  localparam logic [2:0] MODE_SET = 3'd1;
  localparam logic [2:0] MODE_CLR = 3'd2;
  localparam logic [2:0] MODE_TGL = 3'd3;
  localparam logic [2:0] MODE_PWM = 3'd6;

  typedef struct packed {
    logic set_sel;
    logic clr_sel;
    logic tgl_sel;
    logic pwm_sel;
  } mode_dec_t;
endpackage

// File: rtl/oc_mode_trk.sv
module oc_mode_trk
  import oc_pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  output logic       enter_o,
  output mode_dec_t  dec_o
);
  logic [2:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else         mode_q <= mode_i;
  end

  assign enter_o = (mode_i != mode_q);

  always_comb begin
    dec_o         = '0;
    dec_o.set_sel = (mode_i == MODE_SET);
    dec_o.clr_sel = (mode_i == MODE_CLR);
    dec_o.tgl_sel = (mode_i == MODE_TGL);
    dec_o.pwm_sel = (mode_i == MODE_PWM);
  end
endmodule

// File: rtl/oc_shot_arm.sv
module oc_shot_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic single_i,
  input  logic enter_i,
  input  logic hit_i,
  output logic fire_o
);
  logic armed_q;
  logic live;

  // arming takes effect in the entry cycle itself
  assign live   = armed_q | enter_i;
  assign fire_o = single_i & hit_i & live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= single_i & live & ~fire_o;
  end
endmodule

// File: rtl/oc_duty_buf.sv
module oc_duty_buf #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] sec_o,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] sec_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_i)   sec_q <= wdata_i;
      if (load_i) act_q <= sec_q;
    end
  end

  assign sec_o = sec_q;
  assign act_o = act_q;
endmodule

// File: rtl/oc_pin_drv.sv
module oc_pin_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic tgl_i,
  input  logic evt_i,
  output logic pin_o,
  output logic irq_o
);
  logic pin_q, pin_d, irq_q;

  always_comb begin
    pin_d = pin_q;
    if (set_i)      pin_d = 1'b1;
    else if (clr_i) pin_d = 1'b0;
    else if (tgl_i) pin_d = ~pin_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
      irq_q <= evt_i;
    end
  end

  assign pin_o = pin_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/oc_pwm_chan.sv
module oc_pwm_chan
  import oc_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tmr_i,
  input  logic             prd_match_i,
  input  logic [2:0]       mode_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             dty_wr_i,
  input  logic [CNT_W-1:0] dty_wdata_i,
  output logic             pin_o,
  output logic             irq_o
);
  mode_dec_t        dec;
  logic             mode_enter;
  logic [CNT_W-1:0] cmp_q, sec_q, act_q;
  logic             cmp_hit, shot_fire, duty_load, duty_nz, act_hit;
  logic             pwm_bnd;
  logic             drv_set, drv_clr, drv_tgl, drv_evt;

  oc_mode_trk u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .enter_o (mode_enter),
    .dec_o   (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (cmp_wr_i) cmp_q <= cmp_wdata_i;
  end

  assign cmp_hit = (tmr_i == cmp_q);

  oc_shot_arm u_arm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .single_i (dec.set_sel | dec.clr_sel),
    .enter_i  (mode_enter),
    .hit_i    (cmp_hit),
    .fire_o   (shot_fire)
  );

  assign pwm_bnd   = dec.pwm_sel & prd_match_i;
  assign duty_load = pwm_bnd | (dec.pwm_sel & mode_enter);

  oc_duty_buf #(.CNT_W(CNT_W)) u_duty (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (dty_wr_i),
    .wdata_i (dty_wdata_i),
    .load_i  (duty_load),
    .sec_o   (sec_q),
    .act_o   (act_q)
  );

  assign duty_nz = |sec_q;
  // active duty is stale on the entry edge; boundary outranks the fall
  assign act_hit = dec.pwm_sel & ~prd_match_i & ~mode_enter & (tmr_i == act_q);

  assign drv_set = (dec.set_sel & shot_fire) | (pwm_bnd & duty_nz);
  assign drv_clr = (dec.clr_sel & shot_fire) | (pwm_bnd & ~duty_nz) | act_hit;
  assign drv_tgl = dec.tgl_sel & cmp_hit;
  assign drv_evt = shot_fire | drv_tgl | pwm_bnd;

  oc_pin_drv u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (drv_set),
    .clr_i  (drv_clr),
    .tgl_i  (drv_tgl),
    .evt_i  (drv_evt),
    .pin_o  (pin_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/oc_pwm_chan_chk.sv
module oc_pwm_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] tmr_i,
  input logic             prd_match_i,
  input logic [2:0]       mode_i,
  input logic             pin_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cmp_q,
  input logic [CNT_W-1:0] sec_q,
  input logic             mode_enter
);
  p_set_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1 && mode_enter && tmr_i == cmp_q) |=> (pin_o && irq_o));

  p_clr_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd2 && mode_enter && tmr_i == cmp_q) |=> (!pin_o && irq_o));

  p_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd3 && tmr_i == cmp_q) |=> (pin_o != $past(pin_o)));

  p_enter_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_enter && mode_i != 3'd6 && tmr_i != cmp_q) |=> $stable(pin_o));

  p_off_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0 || mode_i == 3'd4 || mode_i == 3'd5 || mode_i == 3'd7)
      |=> ($stable(pin_o) && !irq_o));

  p_zero_duty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd6 && prd_match_i && sec_q == '0) |=> !pin_o);

  p_bnd_event_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd6 && prd_match_i) |=> irq_o);
endmodule

bind oc_pwm_chan oc_pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tmr_i       (tmr_i),
  .prd_match_i (prd_match_i),
  .mode_i      (mode_i),
  .pin_o       (pin_o),
  .irq_o       (irq_o),
  .cmp_q       (cmp_q),
  .sec_q       (sec_q),
  .mode_enter  (mode_enter)
);

// File: tb/oc_pwm_chan_test.sv
module oc_pwm_chan_test;
  localparam int W    = 4;
  localparam int P    = 9;
  localparam int NONE = 15;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b1;
  logic [W-1:0] tmr = '0;
  logic         prd = 1'b0;
  logic [2:0]   mode = 3'd0;
  logic         cmp_wr = 1'b0, dty_wr = 1'b0;
  logic [W-1:0] cmp_wd = '0, dty_wd = '0;
  logic         pin, irq;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  bit  exp_pin;

  always #2 clk = ~clk;

  oc_pwm_chan #(.CNT_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tmr_i(tmr), .prd_match_i(prd),
    .mode_i(mode), .cmp_wr_i(cmp_wr), .cmp_wdata_i(cmp_wd),
    .dty_wr_i(dty_wr), .dty_wdata_i(dty_wd), .pin_o(pin), .irq_o(irq)
  );

  task automatic chk(input logic got, input logic exp, input string rq, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at t=%0t", rq, what, got, exp, $time);
    end
  endtask

  task automatic step(input int t);
    tmr = W'(t);
    prd = (t == P);
    @(posedge clk);
    @(negedge clk);
    cmp_wr = 1'b0;
    dty_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int    d_act, d_nxt;
    string rq;
    bit    e;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(pin, 1'b0, "R1", "pin in reset");
    chk(irq, 1'b0, "R1", "irq in reset");
    rst_ni = 1'b1;
    step(NONE);
    chk(pin, 1'b0, "R1", "pin after reset");
    exp_pin = 1'b0;

    // single-shot modes, every compare value
    for (int c = 0; c <= P; c++) begin
      for (int m = 1; m <= 2; m++) begin
        bit tgt;
        tgt = (m == 1);
        mode = 3'd0; cmp_wr = 1'b1; cmp_wd = W'(c);
        step(NONE);
        chk(pin, exp_pin, "R6", "hold in off");
        mode = 3'(m);
        step(NONE);
        chk(pin, exp_pin, "R5", "enable shot");
        chk(irq, 1'b0, "R5", "enable shot irq");
        for (int k = 0; k <= P; k++) begin
          step(k);
          if (k == c) exp_pin = tgt;
          chk(pin, exp_pin, (m == 1) ? "R2" : "R3", "first match");
          chk(irq, (k == c), "R11", "shot irq");
        end
        for (int k = 0; k <= P; k++) begin
          step(k);
          chk(pin, tgt, (m == 1) ? "R2" : "R3", "rearm blocked");
          chk(irq, 1'b0, (m == 1) ? "R2" : "R3", "no second irq");
        end
      end
    end

    // toggle mode, every compare value
    for (int c = 0; c <= P; c++) begin
      mode = 3'd0; cmp_wr = 1'b1; cmp_wd = W'(c);
      step(NONE);
      mode = 3'd3;
      step(NONE);
      chk(pin, exp_pin, "R5", "enable toggle");
      for (int r = 0; r < 2; r++) begin
        for (int k = 0; k <= P; k++) begin
          step(k);
          if (k == c) exp_pin = ~exp_pin;
          chk(pin, exp_pin, "R4", "toggle");
          chk(irq, (k == c), "R11", "toggle irq");
        end
      end
    end

    // off and unused codes: compare value P still stored
    for (int i = 0; i < 4; i++) begin
      mode = (i == 0) ? 3'd0 : (i == 1) ? 3'd4 : (i == 2) ? 3'd5 : 3'd7;
      for (int k = 0; k <= P; k++) begin
        step(k);
        chk(pin, exp_pin, "R6", "hold code");
        chk(irq, 1'b0, "R6", "no irq code");
      end
    end

    // PWM: duty sequence 0,0,1,0,2,0,...,15,0
    mode = 3'd0; dty_wr = 1'b1; dty_wd = '0;
    step(NONE);
    mode = 3'd6;
    step(NONE);
    chk(pin, exp_pin, "R5", "enable pwm");
    d_act = 0;
    for (int j = 0; j < 32; j++) begin
      d_nxt = (j % 2 == 0) ? j / 2 : 0;
      for (int k = 0; k <= P; k++) begin
        if (k == 0) begin
          dty_wr = 1'b1;
          dty_wd = W'(d_nxt);
        end
        step(k);
        if (k < P) begin
          e  = (d_act != 0) && (k < d_act);
          rq = (d_act == 0) ? "R9" : (d_act >= P) ? "R10" : "R7";
        end else begin
          e  = (d_nxt != 0);
          rq = (d_act == 0 && d_nxt != 0) ? "R9" : "R8";
        end
        chk(pin, e, rq, "pwm level");
        chk(irq, (k == P), "R11", "pwm irq");
      end
      d_act = d_nxt;
    end

    finish_run();
  end
endmodule